// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects an internal byte-wide read/write request port to an asynchronous external static memory bus. The external bus has three parts. One 8-bit port carries the low address byte first and the data byte after it. A separate 8-bit port carries the high address byte. Three active strobes (an address latch enable, an active-low read and an active-low write) tell the external latch and memory what each phase holds. All strobe edges follow the internal clock, and no clock leaves the block.

Every access runs through fixed phases. The address phase pulses the latch enable. In the strobe phase the read or write strobe is held low, and the wait states are added there. A closing phase carries a one-cycle done pulse and, for reads, the sampled data. The high byte of the address space is compared against a programmable boundary, and the result picks one of two 2-bit wait fields. This lets a slow device and a fast device sit on the same bus. The closing phase repeats the latch-enable pulse only when the requester marks the following access as a memory access. An optional bus keeper holds the last value on the shared port while the bus is idle.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the block is idle: busy=0, done=0, ale=0, rd_n=1, wr_n=1.
- R2: A request seen while idle starts the address phase on the next cycle. In that phase ale=1, ad_oe=1, ad_out is the low address byte and a_hi is the high address byte. a_hi keeps the high byte for the whole access and after it.
- R3: The strobe (rd_n for a read, wr_n for a write) goes low in the cycle after the address phase and stays low for 2+N cycles. N is 0, 1, 2 or 2 for the wait codes 00, 01, 10 and 11. ale is low and the other strobe is high while it is low.
- R4: When the high address byte is at or above cfg_boundary, the access uses cfg_wait_hi. Otherwise it uses cfg_wait_lo. The configuration is taken when the request is accepted.
- R5: Wait code 11 adds one address-hold cycle after the strobe rises. In that cycle both strobes are high, ale is low and done is low. An access then lasts 5+N cycles; with any other code it lasts 4+N cycles.
- R6: For a read, rdata takes the value of ad_in on the last cycle of the strobe and presents it with done. A write leaves rdata unchanged.
- R7: done is high for exactly one cycle, in the last cycle of each access.
- R8: In the done cycle, ale is high exactly when the request's req_next_ram bit was 1.
- R9: busy is high from the address phase through the done cycle. A request presented while busy is ignored: it changes neither the access in progress nor the idle state that follows.
- R10: For a write, ad_oe=1 and ad_out=write data from the first strobe cycle to the end of the access.
- R11: While idle with cfg_keeper=1, ad_oe=1 and ad_out holds the last data byte seen on the bus (the write data, or the sampled read data). With cfg_keeper=0 the port is released when idle (ad_oe=0).
- R12: For a read, ad_oe is 0 from the first strobe cycle to the end of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_next_ram | input | 1 | The following access is also a memory access |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| cfg_boundary | input | 8 | High-byte threshold of the upper sector |
| cfg_wait_lo | input | 2 | Wait code of the lower sector |
| cfg_wait_hi | input | 2 | Wait code of the upper sector |
| cfg_keeper | input | 1 | Hold the shared port while idle |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last read data |
| ad_out | output | 8 | Shared address/data port, output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port, input value |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with the package defaults: a 16-bit address, an 8-bit data byte and a 2-bit wait code. These values are small enough for a full sweep. Every pair of lower and upper wait codes is tried with reads and writes, with the keeper on and off, and with the trailing latch-enable flag set and clear. The boundary is set to 0x00, 0x40 and 0xFF, and addresses just below it, at it and at the top of the space are used. ad_in changes on every cycle, so a read shows which cycle was sampled. The request inputs are scrambled throughout each access to show they are ignored.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int unsigned XM_DATA_W  = 8;
    localparam int unsigned XM_ADDR_W  = 16;
    localparam int unsigned XM_HI_W    = XM_ADDR_W - XM_DATA_W;
    localparam int unsigned XM_WAIT_W  = 2;
    localparam int unsigned XM_MAXWAIT = 2;
    localparam int unsigned XM_CNT_W   = $clog2(XM_MAXWAIT + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_WAIT,
        PH_T3,
        PH_HOLD,
        PH_T4
    } xm_phase_e;

    typedef struct packed {
        logic                 write;
        logic                 next_ram;
        logic [XM_ADDR_W-1:0] addr;
        logic [XM_DATA_W-1:0] wdata;
        logic [XM_CNT_W-1:0]  nwait;
        logic                 hold;
    } xm_access_t;

    // number of strobe-stretching cycles for a wait code
    function automatic logic [XM_CNT_W-1:0] xm_wait_cycles(input logic [XM_WAIT_W-1:0] code);
        case (code)
            2'b00:   return XM_CNT_W'(0);
            2'b01:   return XM_CNT_W'(1);
            default: return XM_CNT_W'(XM_MAXWAIT);
        endcase
    endfunction

    // the top code also adds an address-hold cycle after the strobe
    function automatic logic xm_has_hold(input logic [XM_WAIT_W-1:0] code);
        return code == '1;
    endfunction

    function automatic logic xm_strobe_phase(input xm_phase_e p);
        return (p == PH_T2) || (p == PH_WAIT) || (p == PH_T3);
    endfunction

endpackage

// File: rtl/xmem_sector_sel.sv
module xmem_sector_sel
    import xmem_pkg::*;
(
    input  logic [XM_HI_W-1:0]   addr_hi,
    input  logic [XM_HI_W-1:0]   boundary,
    input  logic [XM_WAIT_W-1:0] wait_lo,
    input  logic [XM_WAIT_W-1:0] wait_hi,
    output logic [XM_WAIT_W-1:0] wait_code
);
    logic upper;

    always_comb begin
        upper     = (addr_hi >= boundary);
        wait_code = upper ? wait_hi : wait_lo;
    end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_next_ram,
    input  logic [XM_ADDR_W-1:0] req_addr,
    input  logic [XM_DATA_W-1:0] req_wdata,
    input  logic [XM_WAIT_W-1:0] wait_code,
    output xm_phase_e            phase,
    output logic                 acc_write,
    output logic                 acc_next_ram,
    output logic [XM_ADDR_W-1:0] acc_addr,
    output logic [XM_DATA_W-1:0] acc_wdata
);
    xm_access_t acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            acc   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        acc.write    <= req_write;
                        acc.next_ram <= req_next_ram;
                        acc.addr     <= req_addr;
                        acc.wdata    <= req_wdata;
                        acc.nwait    <= xm_wait_cycles(wait_code);
                        acc.hold     <= xm_has_hold(wait_code);
                        phase        <= PH_T1;
                    end
                end
                PH_T1:   phase <= PH_T2;
                PH_T2:   phase <= (acc.nwait != '0) ? PH_WAIT : PH_T3;
                PH_WAIT: begin
                    acc.nwait <= acc.nwait - XM_CNT_W'(1);
                    if (acc.nwait == XM_CNT_W'(1)) phase <= PH_T3;
                end
                PH_T3:   phase <= acc.hold ? PH_HOLD : PH_T4;
                PH_HOLD: phase <= PH_T4;
                PH_T4:   phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        acc_write    = acc.write;
        acc_next_ram = acc.next_ram;
        acc_addr     = acc.addr;
        acc_wdata    = acc.wdata;
    end
endmodule

// File: rtl/xmem_bus_drv.sv
module xmem_bus_drv
    import xmem_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  xm_phase_e            phase,
    input  logic                 acc_write,
    input  logic                 acc_next_ram,
    input  logic [XM_ADDR_W-1:0] acc_addr,
    input  logic [XM_DATA_W-1:0] acc_wdata,
    input  logic                 keeper,
    input  logic [XM_DATA_W-1:0] ad_in,
    output logic                 busy,
    output logic                 done,
    output logic [XM_DATA_W-1:0] rdata,
    output logic [XM_DATA_W-1:0] ad_out,
    output logic                 ad_oe,
    output logic [XM_HI_W-1:0]   a_hi,
    output logic                 ale,
    output logic                 rd_n,
    output logic                 wr_n
);
    logic [XM_DATA_W-1:0] held;
    logic                 strobe;
    logic                 wr_drive;

    always_comb begin
        strobe   = xm_strobe_phase(phase);
        wr_drive = acc_write && (strobe || phase == PH_HOLD || phase == PH_T4);
        busy     = (phase != PH_IDLE);
        done     = (phase == PH_T4);
        ale      = (phase == PH_T1) || ((phase == PH_T4) && acc_next_ram);
        rd_n     = !(strobe && !acc_write);
        wr_n     = !(strobe && acc_write);
        ad_oe    = (phase == PH_T1) || wr_drive || ((phase == PH_IDLE) && keeper);
        if (phase == PH_T1)
            ad_out = acc_addr[XM_DATA_W-1:0];
        else if (wr_drive)
            ad_out = acc_wdata;
        else
            ad_out = held;
        a_hi = acc_addr[XM_ADDR_W-1:XM_DATA_W];
    end

    // keeper value follows whatever last sat on the shared port
    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            rdata <= '0;
        end else begin
            case (phase)
                PH_T1: held <= acc_addr[XM_DATA_W-1:0];
                PH_T2: if (acc_write) held <= acc_wdata;
                PH_T3: if (!acc_write) begin
                    held  <= ad_in;
                    rdata <= ad_in;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
    import xmem_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_next_ram,
    input  logic [XM_ADDR_W-1:0] req_addr,
    input  logic [XM_DATA_W-1:0] req_wdata,
    input  logic [XM_HI_W-1:0]   cfg_boundary,
    input  logic [XM_WAIT_W-1:0] cfg_wait_lo,
    input  logic [XM_WAIT_W-1:0] cfg_wait_hi,
    input  logic                 cfg_keeper,
    output logic                 busy,
    output logic                 done,
    output logic [XM_DATA_W-1:0] rdata,
    output logic [XM_DATA_W-1:0] ad_out,
    output logic                 ad_oe,
    input  logic [XM_DATA_W-1:0] ad_in,
    output logic [XM_HI_W-1:0]   a_hi,
    output logic                 ale,
    output logic                 rd_n,
    output logic                 wr_n
);
    logic [XM_WAIT_W-1:0] wait_code;
    xm_phase_e            phase;
    logic                 acc_write;
    logic                 acc_next_ram;
    logic [XM_ADDR_W-1:0] acc_addr;
    logic [XM_DATA_W-1:0] acc_wdata;

    xmem_sector_sel i_sector (
        .addr_hi   (req_addr[XM_ADDR_W-1:XM_DATA_W]),
        .boundary  (cfg_boundary),
        .wait_lo   (cfg_wait_lo),
        .wait_hi   (cfg_wait_hi),
        .wait_code (wait_code)
    );

    xmem_seq i_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_next_ram (req_next_ram),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .wait_code    (wait_code),
        .phase        (phase),
        .acc_write    (acc_write),
        .acc_next_ram (acc_next_ram),
        .acc_addr     (acc_addr),
        .acc_wdata    (acc_wdata)
    );

    xmem_bus_drv i_drv (
        .clk          (clk),
        .rst          (rst),
        .phase        (phase),
        .acc_write    (acc_write),
        .acc_next_ram (acc_next_ram),
        .acc_addr     (acc_addr),
        .acc_wdata    (acc_wdata),
        .keeper       (cfg_keeper),
        .ad_in        (ad_in),
        .busy         (busy),
        .done         (done),
        .rdata        (rdata),
        .ad_out       (ad_out),
        .ad_oe        (ad_oe),
        .a_hi         (a_hi),
        .ale          (ale),
        .rd_n         (rd_n),
        .wr_n         (wr_n)
    );
endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk
    import xmem_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [XM_ADDR_W-1:0] req_addr,
    input logic                 cfg_keeper,
    input logic                 busy,
    input logic                 done,
    input logic [XM_DATA_W-1:0] ad_out,
    input logic                 ad_oe,
    input logic [XM_HI_W-1:0]   a_hi,
    input logic                 ale,
    input logic                 rd_n,
    input logic                 wr_n
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && !ale && rd_n && wr_n));

    a_r2_address_phase: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (ale && ad_oe
            && ad_out == $past(req_addr[XM_DATA_W-1:0])
            && a_hi == $past(req_addr[XM_ADDR_W-1:XM_DATA_W])));

    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    a_r3_no_ale_in_strobe: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> (!ale && busy));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_while_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy && rd_n && wr_n));

    a_r10_write_drives: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    a_r12_read_releases: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    a_r11_keeper_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ad_oe == cfg_keeper));
endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .cfg_keeper (cfg_keeper),
    .busy       (busy),
    .done       (done),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .a_hi       (a_hi),
    .ale        (ale),
    .rd_n       (rd_n),
    .wr_n       (wr_n)
);

// File: tb/test_xmem_bus_ctrl.sv
module test_xmem_bus_ctrl;
    import xmem_pkg::*;

    localparam time CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic       req_next_ram = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [7:0] cfg_boundary = '0;
    logic [1:0] cfg_wait_lo = '0;
    logic [1:0] cfg_wait_hi = '0;
    logic       cfg_keeper = 1'b0;
    logic       busy, done, ad_oe, ale, rd_n, wr_n;
    logic [7:0] rdata, ad_out, a_hi;
    logic [7:0] ad_in = '0;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [7:0] last_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmem_bus_ctrl i_xmem_bus_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_next_ram(req_next_ram), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_boundary(cfg_boundary), .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi),
        .cfg_keeper(cfg_keeper), .busy(busy), .done(done), .rdata(rdata),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic check_eq(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic run_access(bit wr, bit nr, logic [15:0] addr, logic [7:0] wd, logic [7:0] base);
        logic [1:0] code;
        int n;
        int hold;
        int len;
        logic [7:0] exp_rd;
        code = (addr[15:8] >= cfg_boundary) ? cfg_wait_hi : cfg_wait_lo;  // R4
        n    = (code == 2'b00) ? 0 : (code == 2'b01) ? 1 : 2;
        hold = (code == 2'b11) ? 1 : 0;
        len  = 4 + n + hold;
        exp_rd = base + 8'(3 + n);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_next_ram = nr;
        req_addr = addr; req_wdata = wd; ad_in = base;
        @(posedge clk);
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            // scrambled request while busy must be ignored (R9)
            req_valid = (k < len); req_write = ~wr; req_next_ram = ~nr;
            req_addr = ~addr; req_wdata = ~wd;
            ad_in = base + 8'(k);
            check_eq("R9 busy", int'(busy), 1);
            check_eq("R2 a_hi", int'(a_hi), int'(addr[15:8]));
            if (k == len) check_eq("R8 trailing ale", int'(ale), int'(nr));
            else          check_eq("R2 ale", int'(ale), (k == 1) ? 1 : 0);
            check_eq("R3 rd_n", int'(rd_n), (!wr && k >= 2 && k <= 3 + n) ? 0 : 1);
            check_eq("R3 wr_n", int'(wr_n), (wr && k >= 2 && k <= 3 + n) ? 0 : 1);
            if (hold == 1 && k == 4 + n) check_eq("R5 hold no done", int'(done), 0);
            else                          check_eq("R4/R7 done", int'(done), (k == len) ? 1 : 0);
            if (k == 1) begin
                check_eq("R2 oe", int'(ad_oe), 1);
                check_eq("R2 ad_out", int'(ad_out), int'(addr[7:0]));
            end else if (wr) begin
                check_eq("R10 oe", int'(ad_oe), 1);
                check_eq("R10 ad_out", int'(ad_out), int'(wd));
            end else begin
                check_eq("R12 oe", int'(ad_oe), 0);
            end
            if (k == len) begin
                if (!wr) last_rdata = exp_rd;
                check_eq("R6 rdata", int'(rdata), int'(last_rdata));
            end
        end
        @(negedge clk);
        check_eq("R9 idle", int'(busy), 0);
        check_eq("R9 no done", int'(done), 0);
        check_eq("R11 oe", int'(ad_oe), int'(cfg_keeper));
        if (cfg_keeper)
            check_eq("R11 held", int'(ad_out), wr ? int'(wd) : int'(exp_rd));
        check_eq("R6 rdata kept", int'(rdata), int'(last_rdata));
    endtask

    initial begin
        logic [7:0] bnds [3];
        logic [7:0] hi;
        bnds[0] = 8'h00; bnds[1] = 8'h40; bnds[2] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1 busy", int'(busy), 0);
        check_eq("R1 done", int'(done), 0);
        check_eq("R1 ale", int'(ale), 0);
        check_eq("R1 rd_n", int'(rd_n), 1);
        check_eq("R1 wr_n", int'(wr_n), 1);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 idle after release", int'(busy), 0);
        for (int kp = 0; kp < 2; kp++)
            for (int bi = 0; bi < 3; bi++)
                for (int wl = 0; wl < 4; wl++)
                    for (int wh = 0; wh < 4; wh++)
                        for (int w = 0; w < 2; w++)
                            for (int nr = 0; nr < 2; nr++)
                                for (int ai = 0; ai < 3; ai++) begin
                                    cfg_keeper   = kp[0];
                                    cfg_boundary = bnds[bi];
                                    cfg_wait_lo  = 2'(wl);
                                    cfg_wait_hi  = 2'(wh);
                                    hi = (ai == 0) ? bnds[bi] - 8'd1 :
                                         (ai == 1) ? bnds[bi] : 8'hFF;
                                    run_access(w[0], nr[0], {hi, 8'(wl * 37 + wh * 11 + ai)},
                                               8'(8'hA5 ^ 8'(wl * 16 + wh)),
                                               8'(bi * 50 + ai * 7 + wl));
                                end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule